// File: doc/BRIEF.md
# Programmable High/Low Clock Divider

This block derives a slower output clock from a fast source clock using a post-scale counter. Two counts set the shape of each output period: one gives the number of source cycles spent high, the other the number spent low. The total divide ratio is their sum, and the duty cycle is the high count over that sum. A half-cycle correction bit moves the falling output edge half a source cycle earlier. An odd total divide can then still give a 50 percent duty cycle: a high count of 2 and a low count of 1 give 1.5 cycles high and 1.5 cycles low.

A small register interface presents a new high count, low count and correction bit together with a one-cycle apply strobe. The values are captured into shadow registers. They reach the counter only at the start of the next high phase, so a change of frequency or duty cycle at run time leaves no runt pulse. A busy flag covers the time between capture and take-over.

Top module: `hilo_clk_div`

## Requirements
- R1: With the correction bit clear, the output stays high for H source cycles and then low for L source cycles, repeating with a period of H+L cycles, where H and L are the applied high and low counts.
- R2: A high or low count of 0 behaves exactly like a count of 1.
- R3: With the correction bit set and an effective high count of at least 2, the high phase lasts H-0.5 source cycles and the low phase lasts L+0.5 source cycles. The falling edge comes at the falling source edge inside the last high cycle.
- R4: The correction bit has no effect when the effective high count is 1. The output is then high for one full cycle and low for L full cycles.
- R5: An apply strobe sampled at a rising source edge while busy is low captures the inputs and raises busy from the next cycle. The current period completes with the old settings. The new settings start with the high phase that begins when the current low phase ends, and busy falls at that same edge.
- R6: An apply strobe sampled while busy is high is ignored. Its values never reach the output.
- R7: An apply strobe sampled at the very edge where a low phase ends does not affect the high phase starting at that edge. It takes effect one full old period later.
- R8: While the synchronous reset is high, the output and busy are low. After reset the settings are high 1, low 1, correction clear. The first high phase starts at the first rising edge after reset is released, giving divide-by-2 at 50 percent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgHigh | input | CNT_W | New high-phase count in source cycles |
| cfgLow | input | CNT_W | New low-phase count in source cycles |
| cfgOdd | input | 1 | New half-cycle correction bit |
| cfgApply | input | 1 | One-cycle strobe that captures the three fields above |
| divClk | output | 1 | Divided output clock |
| busy | output | 1 | High from a captured strobe until its settings are in effect |

## Verification
Two functions can meet on the same rising edge: capture of an apply strobe, and the end of a low phase where a pending reload would be taken over. The bench waits for a falling output edge of a known 2/2 setting. It then raises the strobe so that it is sampled on exactly the edge where the next high phase starts. The check is that this high phase and the following low phase keep the old lengths, that busy is still high, and that only the high phase after that carries the new count. A second case places one strobe on the edge right after another, while busy is set. The expected output shows the first setting and no trace of the second.

// File: rtl/hilo_div_pkg.sv
package hilo_div_pkg;

  // Strobes passed from the reload control to the counter datapath.
  typedef struct packed {
    logic load;   // take the shadow settings over at this edge
  } divStrobe_t;

endpackage

// File: rtl/hilo_div_ctrl.sv
module hilo_div_ctrl
  import hilo_div_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfgHigh,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic             cfgOdd,
  input  logic             cfgApply,
  input  logic             endLow,
  output logic [CNT_W-1:0] pendHigh,
  output logic [CNT_W-1:0] pendLow,
  output logic             pendOdd,
  output logic             busy,
  output divStrobe_t       strobes
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] effHigh;
  logic [CNT_W-1:0] effLow;
  logic             effOdd;
  logic             capture;

  // Clamp once at capture so the counter path sees only legal values.
  always_comb begin
    effHigh = (cfgHigh == '0) ? ONE : cfgHigh;
    effLow  = (cfgLow  == '0) ? ONE : cfgLow;
    effOdd  = cfgOdd && (effHigh != ONE);
  end

  assign capture      = cfgApply && !busy;
  assign strobes.load = busy && endLow;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      pendHigh <= ONE;
      pendLow  <= ONE;
      pendOdd  <= 1'b0;
    end else if (capture) begin
      busy     <= 1'b1;
      pendHigh <= effHigh;
      pendLow  <= effLow;
      pendOdd  <= effOdd;
    end else if (strobes.load) begin
      busy     <= 1'b0;
    end
  end

  AST_APPLY_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cfgApply && !busy) |=> busy); // R5
  AST_BUSY_UNTIL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (busy && !strobes.load) |=> busy); // R6
  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(pendHigh) && $stable(pendLow) && $stable(pendOdd))); // R6
  AST_SHADOW_NONZERO: assert property (@(posedge clk) disable iff (rst)
    busy |-> (pendHigh != '0 && pendLow != '0)); // R2

endmodule

// File: rtl/hilo_div_dp.sv
module hilo_div_dp
  import hilo_div_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  divStrobe_t       strobes,
  input  logic [CNT_W-1:0] pendHigh,
  input  logic [CNT_W-1:0] pendLow,
  input  logic             pendOdd,
  output logic             endLow,
  output logic             divClk
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             phaseHigh;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] actHigh;
  logic [CNT_W-1:0] actLow;
  logic             actOdd;
  logic             lastOddHigh;
  logic             cutReg;

  assign endLow      = !phaseHigh && (cnt == '0);
  assign lastOddHigh = phaseHigh && (cnt == '0) && actOdd;

  // Rising-edge phase counter; cnt holds the cycles left in this phase minus one.
  always_ff @(posedge clk) begin
    if (rst) begin
      phaseHigh <= 1'b0;
      cnt       <= '0;
      actHigh   <= ONE;
      actLow    <= ONE;
      actOdd    <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end else if (phaseHigh) begin
      phaseHigh <= 1'b0;
      cnt       <= actLow - ONE;
    end else begin
      phaseHigh <= 1'b1;
      if (strobes.load) begin
        actHigh <= pendHigh;
        actLow  <= pendLow;
        actOdd  <= pendOdd;
        cnt     <= pendHigh - ONE;
      end else begin
        cnt     <= actHigh - ONE;
      end
    end
  end

  // Falling-edge register that cuts the last high cycle in half.
  always_ff @(negedge clk) begin
    if (rst) cutReg <= 1'b0;
    else     cutReg <= lastOddHigh;
  end

  assign divClk = phaseHigh && !cutReg;

  AST_LOAD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    strobes.load |-> endLow); // R5
  AST_LOAD_STARTS_HIGH: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (phaseHigh && cnt == pendHigh - ONE)); // R5
  AST_HIGH_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    phaseHigh |-> (cnt < actHigh)); // R1
  AST_LOW_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    !phaseHigh |-> (cnt < actLow)); // R1
  AST_PHASE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$stable(phaseHigh) |-> ($past(cnt) == '0)); // R1
  AST_ODD_NEEDS_WIDE: assert property (@(posedge clk) disable iff (rst)
    actOdd |-> (actHigh != ONE)); // R4

endmodule

// File: rtl/hilo_clk_div.sv
module hilo_clk_div
  import hilo_div_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfgHigh,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic             cfgOdd,
  input  logic             cfgApply,
  output logic             divClk,
  output logic             busy
);

  divStrobe_t       strobes;
  logic             endLow;
  logic [CNT_W-1:0] pendHigh;
  logic [CNT_W-1:0] pendLow;
  logic             pendOdd;

  hilo_div_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cfgHigh  (cfgHigh),
    .cfgLow   (cfgLow),
    .cfgOdd   (cfgOdd),
    .cfgApply (cfgApply),
    .endLow   (endLow),
    .pendHigh (pendHigh),
    .pendLow  (pendLow),
    .pendOdd  (pendOdd),
    .busy     (busy),
    .strobes  (strobes)
  );

  hilo_div_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .pendHigh (pendHigh),
    .pendLow  (pendLow),
    .pendOdd  (pendOdd),
    .endLow   (endLow),
    .divClk   (divClk)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!divClk && !busy)); // R8

endmodule

// File: tb/hilo_clk_div_tb.sv
module hilo_clk_div_tb;

  localparam int CNT_W = 3;
  localparam int MAXC  = (1 << CNT_W);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] cfgHigh = '0;
  logic [CNT_W-1:0] cfgLow = '0;
  logic             cfgOdd = 1'b0;
  logic             cfgApply = 1'b0;
  logic             divClk;
  logic             busy;

  int checks = 0;
  int failures = 0;

  hilo_clk_div #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .cfgHigh(cfgHigh), .cfgLow(cfgLow),
    .cfgOdd(cfgOdd), .cfgApply(cfgApply), .divClk(divClk), .busy(busy)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One sample per source half-cycle, 2 ns after each clock edge.
  task automatic halfSample(output logic v);
    @(clk);
    #2;
    v = divClk;
  endtask

  // Length in half-cycles of the next complete high phase and its low phase.
  task automatic measure(output int hi, output int lo);
    logic v;
    halfSample(v);
    while (v) halfSample(v);
    while (!v) halfSample(v);
    hi = 0;
    while (v) begin hi++; halfSample(v); end
    lo = 0;
    while (!v) begin lo++; halfSample(v); end
  endtask

  task automatic applyCfg(input int h, input int l, input bit o);
    @(posedge clk); #2;
    cfgHigh = CNT_W'(h); cfgLow = CNT_W'(l); cfgOdd = o; cfgApply = 1'b1;
    @(posedge clk); #2;
    cfgApply = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) begin @(posedge clk); #2; end
  endtask

  initial begin
    #(8 * 190000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hi, lo, eh, el, eo;
    logic v;

    // R8: reset state and default divide-by-2
    repeat (3) @(posedge clk);
    #2;
    check(divClk == 1'b0, "R8 output low in reset", int'(divClk), 0);
    check(busy == 1'b0, "R8 busy low in reset", int'(busy), 0);
    rst = 1'b0;
    @(posedge clk); #2;
    check(divClk == 1'b1, "R8 first high after release", int'(divClk), 1);
    measure(hi, lo);
    check(hi == 2, "R8 default high half-cycles", hi, 2);
    check(lo == 2, "R8 default low half-cycles", lo, 2);

    // R1 R2 R3 R4: sweep every count pair and correction value
    for (int h = 0; h < MAXC; h++) begin
      for (int l = 0; l < MAXC; l++) begin
        for (int o = 0; o < 2; o++) begin
          applyCfg(h, l, o[0]);
          check(busy == 1'b1, "R5 busy after strobe", int'(busy), 1);
          waitIdle();
          measure(hi, lo);
          eh = (h == 0) ? 1 : h;
          el = (l == 0) ? 1 : l;
          eo = (o == 1 && eh > 1) ? 1 : 0;
          if (o == 1 && eh == 1) begin
            check(hi == 2 * eh, "R4 high ignores correction", hi, 2 * eh);
            check(lo == 2 * el, "R4 low ignores correction", lo, 2 * el);
          end else if (eo == 1) begin
            check(hi == 2 * eh - 1, "R3 shortened high", hi, 2 * eh - 1);
            check(lo == 2 * el + 1, "R3 lengthened low", lo, 2 * el + 1);
          end else if (h == 0 || l == 0) begin
            check(hi == 2 * eh, "R2 zero high as one", hi, 2 * eh);
            check(lo == 2 * el, "R2 zero low as one", lo, 2 * el);
          end else begin
            check(hi == 2 * eh, "R1 high length", hi, 2 * eh);
            check(lo == 2 * el, "R1 low length", lo, 2 * el);
          end
        end
      end
    end

    // R6: second strobe while busy is ignored
    applyCfg(4, 4, 1'b0);
    waitIdle();
    @(posedge clk); #2;
    cfgHigh = 3'd2; cfgLow = 3'd2; cfgOdd = 1'b0; cfgApply = 1'b1;
    @(posedge clk); #2;
    cfgHigh = 3'd3; cfgLow = 3'd1; cfgOdd = 1'b1;
    @(posedge clk); #2;
    cfgApply = 1'b0;
    waitIdle();
    measure(hi, lo);
    check(hi == 4, "R6 ignored strobe high", hi, 4);
    check(lo == 4, "R6 ignored strobe low", lo, 4);
    measure(hi, lo);
    check(hi == 4, "R6 ignored strobe high later", hi, 4);

    // R7 R5: strobe sampled on the edge that ends a low phase
    applyCfg(2, 2, 1'b0);
    waitIdle();
    @(negedge divClk);
    @(posedge clk); #2;
    cfgHigh = 3'd3; cfgLow = 3'd3; cfgOdd = 1'b0; cfgApply = 1'b1;
    @(posedge clk); #2;
    cfgApply = 1'b0;
    check(divClk == 1'b1, "R7 high started at boundary", int'(divClk), 1);
    check(busy == 1'b1, "R7 still busy at boundary", int'(busy), 1);
    v = divClk;
    hi = 0;
    while (v) begin hi++; halfSample(v); end
    lo = 0;
    while (!v) begin lo++; halfSample(v); end
    check(hi == 4, "R7 boundary high keeps old length", hi, 4);
    check(lo == 4, "R7 following low keeps old length", lo, 4);
    check(busy == 1'b0, "R5 busy falls at takeover", int'(busy), 0);
    hi = 0;
    while (v) begin hi++; halfSample(v); end
    check(hi == 6, "R5 new high after old period", hi, 6);

    // R8: reset in mid-run restores divide-by-2
    applyCfg(5, 5, 1'b1);
    waitIdle();
    @(posedge clk); #2;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(divClk == 1'b0, "R8 output low in mid-run reset", int'(divClk), 0);
    check(busy == 1'b0, "R8 busy low in mid-run reset", int'(busy), 0);
    rst = 1'b0;
    @(posedge clk); #2;
    check(divClk == 1'b1, "R8 high after mid-run release", int'(divClk), 1);
    measure(hi, lo);
    check(hi == 2, "R8 high after mid-run reset", hi, 2);
    check(lo == 2, "R8 low after mid-run reset", lo, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule